// File: doc/BRIEF.md
# Minimum-Pulse PWM Generator with Error Feedback

This block drives one power switch with an edge-aligned PWM waveform and never emits an on-time or off-time shorter than a configured minimum. Once per period it takes a duty target and adds the residue left over from the previous period. If that sum falls inside a forbidden band near either rail, the block applies the nearer of the band edge or the rail (0% or 100%). It then carries the part it could not apply into the next period. Because this is first-order error feedback with no random dither, the applied compare values average out to the requested duty.

The duty target is a fixed-point count of counter ticks with `FRAC_W` fractional bits below the compare resolution. The truncated fraction joins the carried residue in the same way as the band snapping error. Duty words arrive on a valid/ready stream. Ready is high only in the last tick of each period, and a word accepted there governs the period that starts on the next cycle. The stream is not buffered. A producer that holds valid low at that tick leaves the previous target in force, and a producer that is not ready simply waits for the next period's last tick. The period length and the minimum pulse are plain configuration inputs, latched at that same edge.

Top module: `pwm_ef_gen`

## Requirements
- R1: A period lasts the latched period value P in ticks. `period_start` is high in the first tick of every period, and `duty_ready` is high only in its last tick.
- R2: In a period with applied compare C, `pwm_out` is high for the first C ticks and low for the rest. C = 0 keeps the output low for the whole period, and C = P keeps it high for the whole period.
- R3: Duty data, period and minimum pulse are taken only at the edge that ends a period. The duty word is taken only if `duty_valid` is high in that tick. Changes at any other time have no effect, and a period without a valid word reuses the previous target.
- R4: The effective request is the target plus the carried residue, saturated to the range 0 to P·2^FRAC_W.
- R5: When the request lies outside both forbidden bands, C is the request divided by 2^FRAC_W with the fraction truncated.
- R6: When the request lies above (P−M)·2^FRAC_W, where M is the minimum pulse, C is P or P−M, whichever is nearer. An exact tie goes to P.
- R7: When the request lies below M·2^FRAC_W, C is 0 or M, whichever is nearer. An exact tie goes to 0.
- R8: Every period, the carried residue becomes the saturated request minus C·2^FRAC_W. Over a run of periods the mean of C tracks the target.
- R9: The residue is zero after reset. It is also discarded when the newly latched minimum pulse differs from the one in force.
- R10: During reset the output is low and `period_start` is low. The first period boundary is taken on the first clock edge after reset is released.
- R11: A minimum pulse larger than half the period is treated as half the period (rounded down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CNT_W | Period length in ticks (0 is treated as 1) |
| cfg_min_pulse | input | CNT_W | Shortest allowed on or off time in ticks |
| duty_valid | input | 1 | Duty word offered |
| duty_ready | output | 1 | High in the last tick of a period; the word is accepted there |
| duty_data | input | CNT_W+FRAC_W | Duty target in ticks, FRAC_W fractional bits |
| pwm_out | output | 1 | PWM output |
| period_start | output | 1 | High in the first tick of each period |

## Verification
A duty word accepted in the ready tick sets the compare value at that edge. Its effect appears from the next cycle, the one in which `period_start` is high, and lasts the next P ticks. Inputs are driven on the falling edge while ready is high. The bench then counts high samples of `pwm_out` on the next P falling edges, beginning with the strobe tick, and compares the count with the expected compare value. The same window confirms that the strobe appears only in the first sample and ready only in the last. Residue effects are checked one or more periods later by chaining targets whose expected compare values are computed by hand.

// File: rtl/pwm_ef_pkg.sv
package pwm_ef_pkg;
  typedef enum logic [1:0] {
    BAND_MID  = 2'd0,
    BAND_LOW  = 2'd1,
    BAND_HIGH = 2'd2
  } band_e;
endpackage

// File: rtl/pwm_ef_timer.sv
module pwm_ef_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_min_pulse,
  output logic             last_tick,
  output logic             period_start,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] minp_q,
  output logic [CNT_W-1:0] next_period,
  output logic [CNT_W-1:0] next_min,
  output logic             min_changed
);
  logic [CNT_W-1:0] half_p;

  always_comb begin
    next_period = (cfg_period == '0) ? CNT_W'(1) : cfg_period;
    half_p      = next_period >> 1;
    next_min    = (cfg_min_pulse > half_p) ? half_p : cfg_min_pulse;
    min_changed = (next_min != minp_q);
    last_tick   = (cnt >= period_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      period_q     <= CNT_W'(1);
      minp_q       <= '0;
      period_start <= 1'b0;
    end else begin
      period_start <= last_tick;
      if (last_tick) begin
        cnt      <= '0;
        period_q <= next_period;
        minp_q   <= next_min;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_ef_shaper.sv
module pwm_ef_shaper
  import pwm_ef_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  localparam int DW    = CNT_W + FRAC_W,
  localparam int EW    = DW + 1
) (
  input  logic [DW-1:0]        target,
  input  logic signed [EW-1:0] err_in,
  input  logic [CNT_W-1:0]     period,
  input  logic [CNT_W-1:0]     minp,
  output logic [CNT_W-1:0]     cmp,
  output logic signed [EW-1:0] err_out
);
  localparam int SW = DW + 2;

  logic signed [SW-1:0] req;
  logic [DW-1:0]        full, sat, lo_edge, hi_edge, over;
  band_e                band;

  always_comb begin
    req     = $signed({2'b00, target}) + $signed({err_in[EW-1], err_in});
    full    = {period, {FRAC_W{1'b0}}};
    lo_edge = {minp, {FRAC_W{1'b0}}};
    hi_edge = {period - minp, {FRAC_W{1'b0}}};

    if (req[SW-1])                          sat = '0;
    else if (req[SW-2:0] > {1'b0, full})    sat = full;
    else                                    sat = req[DW-1:0];

    if (sat < lo_edge)       band = BAND_LOW;
    else if (sat > hi_edge)  band = BAND_HIGH;
    else                     band = BAND_MID;

    over = sat - hi_edge;

    case (band)
      BAND_LOW:  cmp = ({sat, 1'b0} > {1'b0, lo_edge}) ? minp : '0;
      BAND_HIGH: cmp = ({over, 1'b0} >= {1'b0, lo_edge}) ? period : (period - minp);
      default:   cmp = sat[DW-1:FRAC_W];
    endcase

    err_out = $signed({1'b0, sat}) - $signed({1'b0, cmp, {FRAC_W{1'b0}}});
  end
endmodule

// File: rtl/pwm_ef_hold.sv
module pwm_ef_hold #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  localparam int DW    = CNT_W + FRAC_W,
  localparam int EW    = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DW-1:0]        tgt_in,
  input  logic [CNT_W-1:0]     cmp_in,
  input  logic signed [EW-1:0] err_in,
  output logic [DW-1:0]        tgt_q,
  output logic [CNT_W-1:0]     cmp_q,
  output logic signed [EW-1:0] err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      cmp_q <= '0;
      err_q <= '0;
    end else if (load) begin
      tgt_q <= tgt_in;
      cmp_q <= cmp_in;
      err_q <= err_in;
    end
  end
endmodule

// File: rtl/pwm_ef_gen.sv
module pwm_ef_gen #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  localparam int DW    = CNT_W + FRAC_W,
  localparam int EW    = DW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_min_pulse,
  input  logic             duty_valid,
  output logic             duty_ready,
  input  logic [DW-1:0]    duty_data,
  output logic             pwm_out,
  output logic             period_start
);
  logic                 last_tick, min_changed;
  logic [CNT_W-1:0]     cnt, period_q, minp_q, next_period, next_min;
  logic [CNT_W-1:0]     cmp_next, cmp_q;
  logic [DW-1:0]        tgt_sel, tgt_q;
  logic signed [EW-1:0] err_carry, err_next, err_q;

  pwm_ef_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_min_pulse(cfg_min_pulse),
    .last_tick(last_tick), .period_start(period_start), .cnt(cnt),
    .period_q(period_q), .minp_q(minp_q),
    .next_period(next_period), .next_min(next_min), .min_changed(min_changed)
  );

  always_comb begin
    tgt_sel   = (duty_valid && last_tick) ? duty_data : tgt_q;
    err_carry = min_changed ? '0 : err_q;
  end

  pwm_ef_shaper #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_shaper (
    .target(tgt_sel), .err_in(err_carry),
    .period(next_period), .minp(next_min),
    .cmp(cmp_next), .err_out(err_next)
  );

  pwm_ef_hold #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(last_tick),
    .tgt_in(tgt_sel), .cmp_in(cmp_next), .err_in(err_next),
    .tgt_q(tgt_q), .cmp_q(cmp_q), .err_q(err_q)
  );

  assign duty_ready = last_tick;
  assign pwm_out    = (cnt < cmp_q);
endmodule

// File: rtl/pwm_ef_checker.sv
module pwm_ef_checker #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  localparam int DW    = CNT_W + FRAC_W,
  localparam int EW    = DW + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 duty_ready,
  input logic                 period_start,
  input logic [CNT_W-1:0]     cnt,
  input logic [CNT_W-1:0]     period_q,
  input logic [CNT_W-1:0]     minp_q,
  input logic [CNT_W-1:0]     cmp_q,
  input logic [DW-1:0]        tgt_q,
  input logic signed [EW-1:0] err_q
);
  logic [EW:0]        bnd_u;
  logic signed [EW:0] bnd_s, err_x;

  always_comb begin
    bnd_u = ({{(EW+1-CNT_W){1'b0}}, minp_q} + (EW+1)'(1)) << FRAC_W;
    bnd_s = $signed(bnd_u);
    err_x = $signed({err_q[EW-1], err_q});
  end

  // R1: the tick after the ready tick starts a new period
  a_r1_start_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
    duty_ready |=> (period_start && cnt == '0));

  // R1: no strobe unless the previous tick ended a period
  a_r1_no_stray_start: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_ready |=> !period_start);

  // R3: latched configuration and target hold within a period
  a_r3_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_ready |=> ($stable(period_q) && $stable(minp_q) && $stable(tgt_q)));

  // R2: compare never exceeds the period
  a_r2_cmp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q <= period_q);

  // R6, R7: applied compare is a rail or lies between the band edges
  a_r7_band_edges: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (cmp_q == '0 || cmp_q == period_q ||
                      (cmp_q >= minp_q && cmp_q <= period_q - minp_q)));

  // R8: carried residue stays within one band width plus one tick
  a_r8_err_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (err_x < bnd_s) && (err_x > -bnd_s));
endmodule

bind pwm_ef_gen pwm_ef_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .duty_ready(duty_ready), .period_start(period_start),
  .cnt(cnt), .period_q(period_q), .minp_q(minp_q), .cmp_q(cmp_q),
  .tgt_q(tgt_q), .err_q(err_q)
);

// File: tb/sim_pwm_ef_gen.sv
`timescale 1ns/1ps
module sim_pwm_ef_gen;
  localparam int CNT_W  = 16;
  localparam int FRAC_W = 16;
  localparam int DW     = CNT_W + FRAC_W;
  localparam int NV     = 24;

  // {duty word, expected high ticks}; P = 100, M = 3
  localparam logic [47:0] VEC [NV] = '{
    {32'h0062_0000, 16'd97 },  // R6 98 -> 97, residue +1
    {32'h0062_0000, 16'd100},  // R6 99 -> 100, residue -1
    {32'h0062_0000, 16'd97 },  // R8 97 -> 97
    {32'h0063_0000, 16'd100},  // R6
    {32'h0050_0000, 16'd79 },  // R4 80 - 1
    {32'h0032_0000, 16'd50 },  // R5
    {32'h0002_0000, 16'd3  },  // R7 2 -> 3
    {32'h0002_0000, 16'd0  },  // R7 1 -> 0
    {32'h0002_0000, 16'd3  },  // R8
    {32'h0000_0000, 16'd0  },  // R2 all low
    {32'h0064_0000, 16'd100},  // R2 all high
    {32'h0001_0000, 16'd0  },  // R7
    {32'h0001_0000, 16'd3  },  // R7 2 -> 3
    {32'h0001_0000, 16'd0  },  // R8
    {32'h0032_8000, 16'd50 },  // R5 fraction carried
    {32'h0032_8000, 16'd51 },  // R5
    {32'h0001_8000, 16'd0  },  // R7 tie 1.5 -> 0
    {32'h0000_8000, 16'd3  },  // R7 2.0 -> 3
    {32'h0001_0000, 16'd0  },  // R8
    {32'h0062_8000, 16'd100},  // R6 tie 98.5 -> 100
    {32'h0063_8000, 16'd97 },  // R6 98 -> 97
    {32'h0060_0000, 16'd97 },  // R8
    {32'h0070_0000, 16'd100},  // R4 saturation
    {32'h0032_0000, 16'd50 }   // R4 excess not carried
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_period = 16'd100;
  logic [CNT_W-1:0] cfg_min_pulse = 16'd3;
  logic             duty_valid = 1'b0;
  logic             duty_ready;
  logic [DW-1:0]    duty_data = '0;
  logic             pwm_out;
  logic             period_start;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_ef_gen #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_min_pulse(cfg_min_pulse),
    .duty_valid(duty_valid), .duty_ready(duty_ready), .duty_data(duty_data),
    .pwm_out(pwm_out), .period_start(period_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!duty_ready);
  endtask

  // entry: at a falling edge with duty_ready high
  task automatic do_period(input logic [DW-1:0] d, input bit v, input int per,
                           input int exp, input string tag, input bit glitch);
    int hi = 0;
    int stray = 0;
    logic [CNT_W-1:0] keep_p;
    duty_data  = d;
    duty_valid = v;
    @(negedge clk);
    duty_valid = 1'b0;
    chk(period_start == 1'b1, {tag, " R1 strobe"}, int'(period_start), 1);
    for (int i = 0; i < per; i++) begin
      if (i > 0) @(negedge clk);
      hi += int'(pwm_out);
      if (i > 0 && period_start) stray++;
      if (i < per - 1 && duty_ready) stray++;
      if (glitch && i == per / 2) begin
        keep_p     = cfg_period;
        duty_valid = 1'b1;
        duty_data  = 32'h0010_0000;
        cfg_period = 16'd40;
      end
      if (glitch && i == per / 2 + 1) begin
        duty_valid = 1'b0;
        cfg_period = keep_p;
      end
    end
    chk(duty_ready == 1'b1, {tag, " R1 ready at last tick"}, int'(duty_ready), 1);
    chk(stray == 0, {tag, " R1 stray strobe/ready"}, stray, 0);
    chk(hi == exp, {tag, " high ticks"}, hi, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(pwm_out == 1'b0, "R10 output low in reset", int'(pwm_out), 0);
    chk(period_start == 1'b0, "R10 no strobe in reset", int'(period_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(period_start == 1'b1, "R10 boundary right after reset", int'(period_start), 1);
    wait_ready();

    for (int k = 0; k < NV; k++)
      do_period(VEC[k][47:16], 1'b1, 100, int'(VEC[k][15:0]), "R4 R5 R6 R7 R8 vector", 1'b0);

    // R3: no valid word, target held; mid-period writes ignored
    do_period(32'h0, 1'b0, 100, 50, "R3 hold with glitch", 1'b1);
    do_period(32'h0, 1'b0, 100, 50, "R3 mid-period write ignored", 1'b0);

    // R9: residue dropped on minimum-pulse change
    do_period(32'h0062_0000, 1'b1, 100, 97, "R9 build residue", 1'b0);
    cfg_min_pulse = 16'd2;
    do_period(32'h0032_0000, 1'b1, 100, 50, "R9 residue cleared", 1'b0);

    // R11: minimum pulse clamped to half the period
    cfg_period    = 16'd20;
    cfg_min_pulse = 16'd15;
    do_period(32'h000C_0000, 1'b1, 20, 10, "R11 clamp", 1'b0);

    // R5, R2 with no band
    cfg_min_pulse = 16'd0;
    do_period(32'h0001_0000, 1'b1, 20, 1, "R5 no band", 1'b0);
    do_period(32'h0000_4000, 1'b1, 20, 0, "R5 fraction kept", 1'b0);
    do_period(32'h0013_C000, 1'b1, 20, 20, "R2 full high", 1'b0);
    do_period(32'h0013_4000, 1'b1, 20, 19, "R5 truncation", 1'b0);
    do_period(32'h0000_0000, 1'b1, 20, 0, "R2 all low", 1'b0);

    // R10: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R10 output low after reset", int'(pwm_out), 0);
    chk(period_start == 1'b0, "R10 strobe low after reset", int'(period_start), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule